// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt lines into an 8-bit pending-request register. A priority resolver downstream reads that register.

Each line is first passed through a two-stage synchroniser. A per-line trigger-mode register then decides how the line is captured:

- **Edge mode:** a rising transition sets the request bit. The bit stays set until the line is acknowledged.
- **Level mode:** the request bit mirrors the synchronised line level.

Software writes the trigger-mode register through a byte-wide write port. Only the bits allowed by the `WR_MASK` parameter can be written, so one design can serve both a master instance (mask 0xF8) and a slave instance (mask 0xDE).

An acknowledge strobe, with a 3-bit binary line number, retires a pending edge request. An initialisation strobe clears all pending requests and the edge history, but leaves the trigger-mode register unchanged. Priority resolution, masking, in-service tracking and vector generation belong to other blocks.

Top module: `irq_trigger_latch`

## Requirements
- R1: After power-on reset, `reqReg` and `trigMode` are both 0x00, which means every line is in edge mode.
- R2: A change on `rawLines` reaches `reqReg` on the third rising clock edge after it is applied: two synchroniser stages plus the request register.
- R3: On an edge-mode line, a low-to-high transition of the synchronised level sets its request bit. The bit stays set after the line falls.
- R4: An edge-mode line that stays high after its request has been acknowledged does not raise a new request until it goes low and high again.
- R5: On a level-mode line, the request bit equals the synchronised level. It is set while the line is high and clears when the line is low.
- R6: An acknowledge (`ackValid` high, `ackLine` = line number 0..7 in binary) clears only that line's request bit, and only when the line is in edge mode.
- R7: An acknowledge of a level-mode line leaves its request bit unchanged.
- R8: When a new rising edge and an acknowledge hit the same edge-mode line in the same cycle, the request bit ends up set.
- R9: A write (`trigWrEn` high) stores `trigWrData & WR_MASK` into `trigMode` on the next clock edge. Bit i = 1 selects level mode for line i; bit i = 0 selects edge mode. Bits outside the mask always read 0.
- R10: `initClr` clears `reqReg` and the stored previous levels on the next edge, and leaves `trigMode` unchanged. As a result, an edge-mode line that is still high raises a new request one edge later.
- R11: The stored previous level is tracked in both modes. A line that is held high while switched from level to edge mode gives no new request once its current request has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| rawLines | input | 8 | Raw, unsynchronised interrupt lines |
| initClr | input | 1 | Initialisation strobe: clears requests and edge history |
| ackValid | input | 1 | Acknowledge strobe |
| ackLine | input | 3 | Binary number of the acknowledged line |
| trigWrEn | input | 1 | Trigger-mode register write strobe |
| trigWrData | input | 8 | Trigger-mode write data |
| reqReg | output | 8 | Pending request register |
| trigMode | output | 8 | Trigger-mode register (1 = level) |

## Verification
The bench targets the following corner cases:

- **Sampling one edge late or early:** a design that does this fails the three-edge latency check.
- **Re-arming an edge line that is held high:** a design that re-arms such a line after acknowledge raises a second, spurious request.
- **Letting acknowledge clear level-mode bits:** such a design drops a line that is still asserted.
- **Letting acknowledge win over a simultaneous new edge:** such a design loses an interrupt.
- **Mode switching and reset interaction:** the bench switches a held-high line from level to edge mode, to catch a previous-level copy that is only updated in edge mode. It also applies `initClr` while a line is high, to catch an initialisation that forgets the edge history or wipes the trigger register.
- **Slave mask:** a second instance with the slave mask confirms that unwritable bits stay zero.

// File: rtl/irqlatch_pkg.sv
package irqlatch_pkg;
  localparam int LINES   = 8;
  localparam int LINE_W  = $clog2(LINES);

  typedef struct packed {
    logic             clrAll;
    logic             trigWr;
    logic [LINES-1:0] ackHit;
  } latchCtrl_t;
endpackage

// File: rtl/irqlatch_ctrl.sv
module irqlatch_ctrl
  import irqlatch_pkg::*;
(
  input  logic              initClr,
  input  logic              ackValid,
  input  logic [LINE_W-1:0] ackLine,
  input  logic              trigWrEn,
  output latchCtrl_t        ctrl
);
  always_comb begin
    ctrl.clrAll = initClr;
    ctrl.trigWr = trigWrEn;
    ctrl.ackHit = '0;
    if (ackValid) ctrl.ackHit[ackLine] = 1'b1;
  end
endmodule

// File: rtl/irqlatch_dp.sv
module irqlatch_dp
  import irqlatch_pkg::*;
#(
  parameter logic [LINES-1:0] WR_MASK     = 8'hF8,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawLines,
  input  logic [LINES-1:0] trigWrData,
  input  latchCtrl_t       ctrl,
  output logic [LINES-1:0] reqReg,
  output logic [LINES-1:0] trigMode
);
  logic [SYNC_STAGES-1:0][LINES-1:0] syncPipe;
  logic [LINES-1:0] lineLvl, prevLvl, rising, reqNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else begin
      syncPipe[0] <= rawLines;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign lineLvl = syncPipe[SYNC_STAGES-1];
  assign rising  = lineLvl & ~prevLvl;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      if (trigMode[i]) reqNext[i] = lineLvl[i];
      else             reqNext[i] = rising[i] | (reqReg[i] & ~ctrl.ackHit[i]);
    end

    // R3: an edge-mode rise sets the request on the next edge
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrl.clrAll && !trigMode[i] && lineLvl[i] && !prevLvl[i]) |=> reqReg[i]);
    // R5: a level-mode request mirrors the synchronised line
    a_r5_level_follows: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrl.clrAll && trigMode[i]) |=> (reqReg[i] == $past(lineLvl[i])));
    // R6: an acknowledge without a new rise retires an edge request
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrl.clrAll && !trigMode[i] && ctrl.ackHit[i] && !(lineLvl[i] && !prevLvl[i]))
        |=> !reqReg[i]);
    // R4: an edge-mode request appears only after a rise
    a_r4_edge_needs_rise: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(reqReg[i]) && !$past(trigMode[i]))
        |-> ($past(lineLvl[i]) && !$past(prevLvl[i])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqReg   <= '0;
      prevLvl  <= '0;
      trigMode <= '0;
    end else begin
      if (ctrl.trigWr) trigMode <= trigWrData & WR_MASK;
      if (ctrl.clrAll) begin
        reqReg  <= '0;
        prevLvl <= '0;
      end else begin
        reqReg  <= reqNext;
        prevLvl <= lineLvl;
      end
    end
  end

  a_r10_init_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrAll |=> (reqReg == '0));
  a_r10_init_keeps_trig: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clrAll && !ctrl.trigWr) |=> $stable(trigMode));
  a_r9_trig_masked_write: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.trigWr |=> (trigMode == ($past(trigWrData) & WR_MASK)));
endmodule

// File: rtl/irq_trigger_latch.sv
module irq_trigger_latch
  import irqlatch_pkg::*;
#(
  parameter logic [7:0] WR_MASK     = 8'hF8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rawLines,
  input  logic       initClr,
  input  logic       ackValid,
  input  logic [2:0] ackLine,
  input  logic       trigWrEn,
  input  logic [7:0] trigWrData,
  output logic [7:0] reqReg,
  output logic [7:0] trigMode
);
  latchCtrl_t ctrl;

  irqlatch_ctrl ctrl_i (
    .initClr(initClr), .ackValid(ackValid), .ackLine(ackLine),
    .trigWrEn(trigWrEn), .ctrl(ctrl)
  );

  irqlatch_dp #(.WR_MASK(WR_MASK), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .rawLines(rawLines), .trigWrData(trigWrData),
    .ctrl(ctrl), .reqReg(reqReg), .trigMode(trigMode)
  );
endmodule

// File: tb/irq_trigger_latch_tb_top.sv
module irq_trigger_latch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rawLines = '0;
  logic initClr = 1'b0, ackValid = 1'b0, trigWrEn = 1'b0;
  logic [2:0] ackLine = '0;
  logic [7:0] trigWrData = '0;
  logic [7:0] reqReg, trigMode, reqSlave, trigSlave;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trigger_latch #(.WR_MASK(8'hF8)) dut_i (
    .clk(clk), .rstN(rstN), .rawLines(rawLines), .initClr(initClr),
    .ackValid(ackValid), .ackLine(ackLine), .trigWrEn(trigWrEn),
    .trigWrData(trigWrData), .reqReg(reqReg), .trigMode(trigMode));

  irq_trigger_latch #(.WR_MASK(8'hDE)) dutSlave_i (
    .clk(clk), .rstN(rstN), .rawLines(rawLines), .initClr(initClr),
    .ackValid(ackValid), .ackLine(ackLine), .trigWrEn(trigWrEn),
    .trigWrData(trigWrData), .reqReg(reqSlave), .trigMode(trigSlave));

  // Requirement model: two sync stages, previous level, request, trigger mode.
  logic [7:0] mS1, mS2, mPrev, mReq, mTrig;

  function automatic logic [7:0] nextReq(logic [7:0] lvl, logic [7:0] prev,
      logic [7:0] req, logic [7:0] trig, logic [7:0] ackMask);
    return (trig & lvl) | (~trig & ((lvl & ~prev) | (req & ~ackMask)));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= '0; mS2 <= '0; mPrev <= '0; mReq <= '0; mTrig <= '0;
    end else begin
      mS1 <= rawLines;
      mS2 <= mS1;
      if (trigWrEn) mTrig <= trigWrData & 8'hF8;
      if (initClr) begin
        mReq <= '0; mPrev <= '0;
      end else begin
        mReq  <= nextReq(mS2, mPrev, mReq, mTrig, ackValid ? (8'h01 << ackLine) : 8'h00);
        mPrev <= mS2;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic ack(int line);
    ackValid = 1'b1; ackLine = 3'(line);
    tick();
    ackValid = 1'b0;
  endtask

  task automatic writeTrig(logic [7:0] d);
    trigWrEn = 1'b1; trigWrData = d;
    tick();
    trigWrEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] r;
    seed = 32'd12345;
    void'($urandom(seed));
    tick(2);
    chk("R1 reqReg after reset", reqReg, 8'h00);
    chk("R1 trigMode after reset", trigMode, 8'h00);
    rstN = 1'b1;
    tick();

    // R2 / R3: lines 3 and 5 rise in edge mode
    rawLines = 8'h28;
    tick(2);
    chk("R2 not yet visible after two edges", reqReg, 8'h00);
    tick();
    chk("R2 R3 edge request on third edge", reqReg, 8'h28);
    rawLines = 8'h08;
    tick(3);
    chk("R3 request held after line falls", reqReg, 8'h28);

    // R6: acknowledge clears only its own line
    ack(5);
    chk("R6 ack line 5 only", reqReg, 8'h08);
    ack(3);
    chk("R6 ack line 3", reqReg, 8'h00);
    tick(3);
    chk("R4 held-high edge line does not re-request", reqReg, 8'h00);
    rawLines = 8'h00;
    tick(3);

    // R9: masked write, master and slave
    writeTrig(8'hFF);
    chk("R9 master masked write", trigMode, 8'hF8);
    chk("R9 slave masked write", trigSlave, 8'hDE);
    writeTrig(8'h07);
    chk("R9 unwritable bits stay zero", trigMode, 8'h00);
    writeTrig(8'hF8);

    // R5: level mode follows line 6
    rawLines = 8'h40;
    tick(3);
    chk("R5 level request set", reqReg, 8'h40);
    rawLines = 8'h00;
    tick(3);
    chk("R5 level request clears with line", reqReg, 8'h00);

    // R7: acknowledge of a level line is ignored
    rawLines = 8'h40;
    tick(3);
    ack(6);
    chk("R7 level ack ignored", reqReg, 8'h40);

    // R11: switch held-high line 6 to edge mode, ack, no new request
    writeTrig(8'h00);
    chk("R11 trig now edge", trigMode, 8'h00);
    ack(6);
    chk("R11 ack after switch clears", reqReg, 8'h00);
    tick(3);
    chk("R11 no spurious edge after switch", reqReg, 8'h00);
    rawLines = 8'h00;
    tick(3);

    // R8: new edge and ack on line 2 in the same cycle
    rawLines = 8'h04;
    tick(2);
    ack(2);
    chk("R8 new edge wins over ack", reqReg, 8'h04);

    // R10: init clears requests and history, keeps trigger mode
    writeTrig(8'h80);
    initClr = 1'b1;
    tick();
    initClr = 1'b0;
    chk("R10 init clears requests", reqReg, 8'h00);
    chk("R10 init keeps trigMode", trigMode, 8'h80);
    tick();
    chk("R10 held-high edge line re-requests after init", reqReg, 8'h04);
    rawLines = 8'h00;
    initClr = 1'b1;
    tick();
    initClr = 1'b0;
    tick(3);

    // Random phase against the requirement model (R2, R3, R5, R6, R9)
    for (int c = 0; c < 3000; c++) begin
      r = $urandom();
      if (r[3:0] == 4'd0) rawLines = rawLines ^ 8'(1 << r[6:4]);
      ackValid = r[9:8] == 2'd0;
      ackLine  = r[12:10];
      trigWrEn = r[17:13] == 5'd0;
      trigWrData = r[25:18];
      initClr  = r[31:24] == 8'd0;
      tick();
      chk("R3 R5 R6 random request vs model", reqReg, mReq);
      chk("R9 random trigMode vs model", trigMode, mTrig);
    end
    ackValid = 1'b0; trigWrEn = 1'b0; initClr = 1'b0;
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule